// File: doc/BRIEF.md
# Bus-Matching Read Port with Endian Ordering

This block sits between the 36-bit output of a FIFO and a read port whose width can be set. It takes one 36-bit long word at a time from the FIFO through a valid/ready handshake. It then hands the word to the port either whole, as two 18-bit half words, or as four 9-bit bytes. A bus-match select and a size select choose the width.

The order of the pieces can be big-endian or little-endian. The block samples the order from a shared pin only while reset is high. After reset, that same pin belongs to other logic, and this block ignores it.

The port side uses a read enable and a valid flag. A piece index tells the consumer which piece of the current long word is on the data output. A new long word is taken from the FIFO only when the last piece of the held word is read. This taking happens in the same cycle as that read, so a continuous reader sees no gap between words.

Top module: `bus_match_rd_port`

## Requirements
- R1: In the first cycle after synchronous reset, rd_valid_o is 0, piece_idx_o is 0 and fifo_ready_o is 1.
- R2: When bm_sel_i is 0, each read returns the whole 36-bit long word, piece_idx_o stays 0, and each read frees the holding slot.
- R3: When bm_sel_i is 1 and size_sel_i is 0, each long word is read as two 18-bit pieces on rd_data_o[17:0], and rd_data_o[35:18] is zero.
- R4: When bm_sel_i is 1 and size_sel_i is 1, each long word is read as four 9-bit pieces on rd_data_o[8:0], and rd_data_o[35:9] is zero.
- R5: If endian_mode_i is 1 at the last reset edge, piece 0 is the most significant slice of the long word, and later pieces step toward the least significant one.
- R6: If endian_mode_i is 0 at the last reset edge, piece 0 is the least significant slice (bits [8:0] or [17:0]), and later pieces step upward.
- R7: Changes of endian_mode_i while reset is low have no effect on the piece order.
- R8: fifo_ready_o is 1 exactly when no word is held, or when rd_en_i reads the last piece of the held word in this cycle. It is 0 otherwise.
- R9: piece_idx_o counts 0, 1, ... up to the piece count minus one, in read order, for each long word.
- R10: While rd_valid_o is 1 and rd_en_i is 0, rd_data_o, piece_idx_o and rd_valid_o keep their values. rd_en_i has no effect while rd_valid_o is 0.
- R11: A new width selection applied while reset is high takes effect for the first long word after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the endian choice is sampled while it is high |
| endian_mode_i | input | 1 | Shared pin; 1 = big-endian, 0 = little-endian, sampled only in reset |
| bm_sel_i | input | 1 | 0 = full 36-bit reads, 1 = narrow reads |
| size_sel_i | input | 1 | With bm_sel_i = 1: 1 = 9-bit bytes, 0 = 18-bit half words |
| fifo_valid_i | input | 1 | FIFO offers a long word |
| fifo_data_i | input | 36 | Long word from the FIFO |
| fifo_ready_o | output | 1 | Block takes the offered word at this edge |
| rd_en_i | input | 1 | Port read enable |
| rd_valid_o | output | 1 | A piece is present on rd_data_o |
| rd_data_o | output | 36 | Current piece, zero-padded above its width |
| piece_idx_o | output | 2 | Position of the current piece within its long word |

## Verification
The checker assumes that bm_sel_i and size_sel_i never change while reset is low. It also assumes that the FIFO side keeps to a valid/ready handshake. The stimulus therefore changes the width selection only inside a reset pulse, and it advances its word pointer only on accepted transfers. The endian pin, by contrast, is deliberately toggled every cycle after reset, so the assertions and checks see that the latched order survives that activity. Read enable and FIFO valid follow different duty cycles, so holds, back-to-back reads and empty cycles all occur in every configuration.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [1:0] {
    WM_FULL = 2'd0,
    WM_HALF = 2'd1,
    WM_BYTE = 2'd2
  } width_mode_e;
endpackage

// File: rtl/bmr_mode_decode.sv
module bmr_mode_decode
  import bmr_pkg::*;
#(
  parameter int BYTE_LANES = 4,
  parameter int HALF_LANES = 2,
  localparam int IDX_W = $clog2(BYTE_LANES)
) (
  input  logic             bm_sel_i,
  input  logic             size_sel_i,
  output width_mode_e      mode_o,
  output logic [IDX_W-1:0] last_idx_o
);
  always_comb begin
    if (!bm_sel_i) begin
      mode_o     = WM_FULL;
      last_idx_o = '0;
    end else if (size_sel_i) begin
      mode_o     = WM_BYTE;
      last_idx_o = IDX_W'(BYTE_LANES - 1);
    end else begin
      mode_o     = WM_HALF;
      last_idx_o = IDX_W'(HALF_LANES - 1);
    end
  end
endmodule

// File: rtl/bmr_seq.sv
module bmr_seq #(
  parameter int DATA_W = 36,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_valid_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_ready_o,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  output logic [DATA_W-1:0] nxt_word_o,
  output logic [IDX_W-1:0]  nxt_cnt_o,
  output logic              vld_o,
  output logic [IDX_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] word_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              vld_q;
  logic              nxt_vld;
  logic              take;
  logic              at_last;
  logic              pop;

  assign take         = rd_en_i && vld_q;
  assign at_last      = (cnt_q == last_idx_i);
  assign fifo_ready_o = !vld_q || (take && at_last);
  assign pop          = fifo_valid_i && fifo_ready_o;

  always_comb begin
    nxt_word_o = word_q;
    nxt_cnt_o  = cnt_q;
    nxt_vld    = vld_q;
    if (pop) begin
      nxt_word_o = fifo_data_i;
      nxt_cnt_o  = '0;
      nxt_vld    = 1'b1;
    end else if (take && at_last) begin
      nxt_cnt_o  = '0;
      nxt_vld    = 1'b0;
    end else if (take) begin
      nxt_cnt_o  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= nxt_word_o;
      cnt_q  <= nxt_cnt_o;
      vld_q  <= nxt_vld;
    end
  end

  assign vld_o = vld_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/bmr_slicer.sv
module bmr_slicer
  import bmr_pkg::*;
#(
  parameter int DATA_W     = 36,
  parameter int BYTE_LANES = 4,
  parameter int HALF_LANES = 2,
  localparam int IDX_W  = $clog2(BYTE_LANES),
  localparam int HIDX_W = $clog2(HALF_LANES),
  localparam int BW     = DATA_W / BYTE_LANES,
  localparam int HW     = DATA_W / HALF_LANES
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [IDX_W-1:0]  cnt_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  input  width_mode_e       mode_i,
  input  logic              big_endian_i,
  output logic [DATA_W-1:0] piece_o
);
  logic [BW-1:0]    byte_lane [BYTE_LANES];
  logic [HW-1:0]    half_lane [HALF_LANES];
  logic [IDX_W-1:0] lane;

  for (genvar g = 0; g < BYTE_LANES; g++) begin : g_byte
    assign byte_lane[g] = word_i[g*BW +: BW];
  end
  for (genvar g = 0; g < HALF_LANES; g++) begin : g_half
    assign half_lane[g] = word_i[g*HW +: HW];
  end

  // Big-endian walks lanes downward from the top one in use.
  assign lane = big_endian_i ? (last_idx_i - cnt_i) : cnt_i;

  always_comb begin
    unique case (mode_i)
      WM_BYTE: piece_o = {{(DATA_W-BW){1'b0}}, byte_lane[lane]};
      WM_HALF: piece_o = {{(DATA_W-HW){1'b0}}, half_lane[lane[HIDX_W-1:0]]};
      default: piece_o = word_i;
    endcase
  end
endmodule

// File: rtl/bus_match_rd_port.sv
module bus_match_rd_port
  import bmr_pkg::*;
#(
  parameter int DATA_W     = 36,
  parameter int BYTE_LANES = 4,
  parameter int HALF_LANES = 2,
  localparam int IDX_W = $clog2(BYTE_LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              endian_mode_i,
  input  logic              bm_sel_i,
  input  logic              size_sel_i,
  input  logic              fifo_valid_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_ready_o,
  input  logic              rd_en_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [IDX_W-1:0]  piece_idx_o
);
  width_mode_e       mode;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] nxt_word;
  logic [IDX_W-1:0]  nxt_cnt;
  logic [DATA_W-1:0] nxt_piece;
  logic [DATA_W-1:0] data_q;
  logic              endian_q;

  // Loads only while reset is high; the pin serves other logic afterwards.
  always_ff @(posedge clk) begin
    if (rst) endian_q <= endian_mode_i;
  end

  bmr_mode_decode #(.BYTE_LANES(BYTE_LANES), .HALF_LANES(HALF_LANES)) dec_i (
    .bm_sel_i   (bm_sel_i),
    .size_sel_i (size_sel_i),
    .mode_o     (mode),
    .last_idx_o (last_idx)
  );

  bmr_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) seq_i (
    .clk          (clk),
    .rst          (rst),
    .fifo_valid_i (fifo_valid_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_ready_o (fifo_ready_o),
    .rd_en_i      (rd_en_i),
    .last_idx_i   (last_idx),
    .nxt_word_o   (nxt_word),
    .nxt_cnt_o    (nxt_cnt),
    .vld_o        (rd_valid_o),
    .cnt_o        (piece_idx_o)
  );

  bmr_slicer #(.DATA_W(DATA_W), .BYTE_LANES(BYTE_LANES), .HALF_LANES(HALF_LANES)) slc_i (
    .word_i       (nxt_word),
    .cnt_i        (nxt_cnt),
    .last_idx_i   (last_idx),
    .mode_i       (mode),
    .big_endian_i (endian_q),
    .piece_o      (nxt_piece)
  );

  // Output piece is registered from the next-state word and count.
  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= nxt_piece;
  end

  assign rd_data_o = data_q;
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker #(
  parameter int DATA_W = 36,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bm_sel_i,
  input logic              size_sel_i,
  input logic              fifo_valid_i,
  input logic              fifo_ready_o,
  input logic              rd_en_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [IDX_W-1:0]  piece_idx_o,
  input logic              endian_q
);
  localparam int BW = DATA_W / 4;
  localparam int HW = DATA_W / 2;

  logic [IDX_W-1:0] top_idx;
  assign top_idx = !bm_sel_i ? IDX_W'(0) : (size_sel_i ? IDX_W'(3) : IDX_W'(1));

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid_o && piece_idx_o == '0)); // R1
  AST_FULL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !bm_sel_i |-> piece_idx_o == '0); // R2
  AST_HALF_PAD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && bm_sel_i && !size_sel_i) |-> rd_data_o[DATA_W-1:HW] == '0); // R3
  AST_BYTE_PAD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && bm_sel_i && size_sel_i) |-> rd_data_o[DATA_W-1:BW] == '0); // R4
  AST_ENDIAN_KEPT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(endian_q)); // R7
  AST_POP_AT_END: assert property (@(posedge clk) disable iff (rst)
    (fifo_valid_i && fifo_ready_o && rd_valid_o) |-> (rd_en_i && piece_idx_o == top_idx)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> piece_idx_o <= top_idx); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_en_i) |=> (rd_valid_o && $stable(rd_data_o) && $stable(piece_idx_o))); // R10
  AST_MODE_STATIC: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(bm_sel_i) && $stable(size_sel_i))); // R11
endmodule

bind bus_match_rd_port bmr_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bm_sel_i     (bm_sel_i),
  .size_sel_i   (size_sel_i),
  .fifo_valid_i (fifo_valid_i),
  .fifo_ready_o (fifo_ready_o),
  .rd_en_i      (rd_en_i),
  .rd_valid_o   (rd_valid_o),
  .rd_data_o    (rd_data_o),
  .piece_idx_o  (piece_idx_o),
  .endian_q     (endian_q)
);

// File: tb/bus_match_rd_port_tb.sv
module bus_match_rd_port_tb_top;
  localparam int NW = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        endian_mode_i = 1'b0;
  logic        bm_sel_i = 1'b0;
  logic        size_sel_i = 1'b0;
  logic        fifo_valid_i = 1'b0;
  logic [35:0] fifo_data_i = '0;
  logic        fifo_ready_o;
  logic        rd_en_i = 1'b0;
  logic        rd_valid_o;
  logic [35:0] rd_data_o;
  logic [1:0]  piece_idx_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bus_match_rd_port dut_i (
    .clk           (clk),
    .rst           (rst),
    .endian_mode_i (endian_mode_i),
    .bm_sel_i      (bm_sel_i),
    .size_sel_i    (size_sel_i),
    .fifo_valid_i  (fifo_valid_i),
    .fifo_data_i   (fifo_data_i),
    .fifo_ready_o  (fifo_ready_o),
    .rd_en_i       (rd_en_i),
    .rd_valid_o    (rd_valid_o),
    .rd_data_o     (rd_data_o),
    .piece_idx_o   (piece_idx_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] word_of(input int i);
    logic [63:0] t;
    t = 64'(i) * 64'h3_5A7C_9E1B + 64'h9_0F1E_2D3C;
    return t[35:0];
  endfunction

  function automatic logic [35:0] piece_of(input logic [35:0] w, input int n, input int k, input bit big);
    int s;
    int pw;
    logic [35:0] m;
    s  = big ? (n - 1 - k) : k;
    pw = 36 / n;
    m  = (n == 1) ? '1 : ((36'd1 << pw) - 36'd1);
    return (w >> (pw * s)) & m;
  endfunction

  task automatic run_cfg(input bit bm, input bit sz, input bit big);
    int n;
    int pw;
    int rw;
    int k;
    bit prev_hold;
    logic [35:0] prev_data;
    logic [1:0] prev_idx;
    bit exp_ready;
    string tg;
    n  = !bm ? 1 : (sz ? 4 : 2);
    tg = (n == 1) ? "R2" : ((n == 2) ? "R3" : "R4");
    tg = {tg, big ? " R5 R7" : " R6 R7"};
    @(negedge clk);
    rst = 1'b1; bm_sel_i = bm; size_sel_i = sz; endian_mode_i = big;
    fifo_valid_i = 1'b0; rd_en_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_valid_o == 1'b0, "R1 valid after reset", 36'(rd_valid_o), 36'd0);
    chk(piece_idx_o == 2'd0, "R1 index after reset", 36'(piece_idx_o), 36'd0);
    chk(fifo_ready_o == 1'b1, "R1 ready after reset", 36'(fifo_ready_o), 36'd1);
    pw = 0; rw = 0; k = 0; prev_hold = 1'b0; prev_data = '0; prev_idx = '0;
    for (int cyc = 0; cyc < 4000 && rw < NW; cyc++) begin
      if (cyc != 0) @(negedge clk);
      if (prev_hold) begin
        chk(rd_valid_o && rd_data_o == prev_data, "R10 data held", rd_data_o, prev_data);
        chk(piece_idx_o == prev_idx, "R10 index held", 36'(piece_idx_o), 36'(prev_idx));
      end
      endian_mode_i = cyc[0];
      rd_en_i       = (cyc % 3) != 1;
      fifo_valid_i  = (pw < NW) && ((cyc % 5) != 3);
      fifo_data_i   = word_of(pw);
      #1;
      exp_ready = !rd_valid_o || (rd_en_i && k == n - 1);
      chk(fifo_ready_o == exp_ready, "R8 ready", 36'(fifo_ready_o), 36'(exp_ready));
      if (rd_valid_o) begin
        chk(piece_idx_o == 2'(k), "R9 piece index", 36'(piece_idx_o), 36'(k));
        if (rd_en_i) begin
          chk(rd_data_o == piece_of(word_of(rw), n, k, big), tg, rd_data_o, piece_of(word_of(rw), n, k, big));
          k++;
          if (k == n) begin
            k = 0;
            rw++;
          end
        end
      end
      prev_hold = rd_valid_o && !rd_en_i;
      prev_data = rd_data_o;
      prev_idx  = piece_idx_o;
      if (fifo_valid_i && fifo_ready_o) pw++;
    end
    chk(rw == NW, "R11 all words read in new width", 36'(rw), 36'(NW));
    @(negedge clk);
    rd_en_i = 1'b0; fifo_valid_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int s = 0; s < 2; s++) begin
        for (int e = 0; e < 2; e++) begin
          run_cfg(b[0], s[0], e[0]);
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule